// File: doc/BRIEF.md
# Snoop Control Register and Private Window Decoder

This block sits at the entrance of a multicore private peripheral window that is 8 KB wide. It decodes a simple request bus with a request strobe, a write enable, a 13-bit byte address and 32-bit write data. Four snoop-control registers live at the bottom of the window. The configuration register is derived from the `NCPU` parameter and reports both a mask of the cores that are present and the core count minus one. The control register stores a single enable bit. The status and invalidate registers read as zero, and a write to either has no effect.

The same decode drives a one-hot select for each neighbouring sub-window. These are the snoop page, one CPU interface page per slot, one timer and one watchdog per slot, and the distributor. Slot 0 is always the alias for the current core, and slot i+1 belongs to core i. Register read data and the error flag come out of a small response state machine. It has two states. `S_IDLE` means no response is due. `S_RESP` means the registered response from the previous cycle's request is on the outputs. There are three transitions: `S_IDLE`→`S_RESP` on a request, `S_RESP`→`S_RESP` on a back-to-back request, and `S_RESP`→`S_IDLE` when no request arrives.

Top module: `snoop_ctl_block`

## Requirements
- R1: After reset, the control register reads zero, and `rdata`, `err` and every select output are zero.
- R2: A write to offset 0x00 keeps only bit 0 of `wdata`. A read of offset 0x00 returns that bit in bit 0 and zero in bits 31:1.
- R3: A read of offset 0x04 returns `(((1<<NCPU)-1)<<4) | (NCPU-1)`, which is 0x000000F3 for `NCPU`=4.
- R4: Reads of offsets 0x08 and 0x0C return zero. A write to 0x0C leaves the control register unchanged.
- R5: An access to any other byte offset in page 0x000–0x0FF raises `err` for one cycle with `rdata` zero, and it leaves the control register unchanged.
- R6: `rdata` and `err` are valid in the cycle after the request cycle. Both are zero in any cycle that does not follow a request. A write returns `rdata` zero.
- R7: Addresses 0x000–0x0FF assert `sel_scu`. Addresses 0x1000–0x1FFF assert `sel_dist`. Both carry no error.
- R8: Page p (address p*0x100) for p = 1 … NCPU+1 asserts `sel_cpuif[p-1]`. Index 0 is the current core and index i+1 is core i.
- R9: In page 6+k, for k = 0 … NCPU, byte offsets 0x00–0x1F assert `sel_timer[k]` and offsets 0x20–0x3F assert `sel_wdog[k]`.
- R10: Any other address (slot above NCPU, offset 0x40 or above in a timer page, or a gap page) asserts no select, and `err` is raised in the next cycle.
- R11: The select outputs are combinational from the current request and are at most one-hot. All of them are zero while `req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Byte address within the private window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the request |
| err | output | 1 | Decode error, one cycle after the request |
| sel_scu | output | 1 | Snoop register page selected |
| sel_cpuif | output | NCPU+1 | CPU interface page select per slot |
| sel_timer | output | NCPU+1 | Timer select per slot |
| sel_wdog | output | NCPU+1 | Watchdog select per slot |
| sel_dist | output | 1 | Distributor selected |

## Verification
The select outputs have no register in their path, so the bench reads them one time unit after it drives a request, inside the request cycle. Read data and the error flag pass through one register. The bench samples them at the falling edge that follows the capturing rising edge, and it does so before the next stimulus changes the request. One cycle later it confirms that both have returned to zero, which checks that a response appears exactly one cycle after its request and never in a later cycle.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 32;
    localparam int PAGE_W = ADDR_W - 8;

    // Snoop register byte offsets (software-visible map)
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CFG   = 8'h04;
    localparam logic [7:0] OFF_STAT  = 8'h08;
    localparam logic [7:0] OFF_INVAL = 8'h0C;

    // Page numbers of the sub-window groups
    localparam int CPUIF_PAGE0 = 1;
    localparam int TIMER_PAGE0 = 6;
    localparam logic [7:0] WDOG_OFF  = 8'h20;
    localparam logic [7:0] TMR_SPAN  = 8'h40;

    typedef enum logic [0:0] {
        S_IDLE,
        S_RESP
    } resp_state_e;

    typedef enum logic [2:0] {
        W_NONE,
        W_SCU,
        W_CPUIF,
        W_TIMER,
        W_WDOG,
        W_DIST
    } win_kind_e;

endpackage

// File: rtl/snoop_win_decode.sv
module snoop_win_decode
    import snoop_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  req,
    input  logic [ADDR_W-1:0]     addr,
    output win_kind_e             kind,
    output logic                  sel_scu,
    output logic [NCPU:0]         sel_cpuif,
    output logic [NCPU:0]         sel_timer,
    output logic [NCPU:0]         sel_wdog,
    output logic                  sel_dist
);
    localparam int NSLOT = NCPU + 1;
    localparam logic [PAGE_W-1:0] CPUIF_LO = PAGE_W'(CPUIF_PAGE0);
    localparam logic [PAGE_W-1:0] CPUIF_HI = PAGE_W'(CPUIF_PAGE0 + NSLOT - 1);
    localparam logic [PAGE_W-1:0] TMR_LO   = PAGE_W'(TIMER_PAGE0);
    localparam logic [PAGE_W-1:0] TMR_HI   = PAGE_W'(TIMER_PAGE0 + NSLOT - 1);

    logic [PAGE_W-1:0] page;
    logic [7:0]        sub;
    logic [PAGE_W-1:0] slot;

    assign page = addr[ADDR_W-1:8];
    assign sub  = addr[7:0];

    always_comb begin
        kind = W_NONE;
        slot = '0;
        if (addr[ADDR_W-1]) begin
            kind = W_DIST;
        end else if (page == '0) begin
            kind = W_SCU;
        end else if (page >= CPUIF_LO && page <= CPUIF_HI) begin
            kind = W_CPUIF;
            slot = page - CPUIF_LO;
        end else if (page >= TMR_LO && page <= TMR_HI) begin
            slot = page - TMR_LO;
            if (sub < WDOG_OFF)      kind = W_TIMER;
            else if (sub < TMR_SPAN) kind = W_WDOG;
            else                     kind = W_NONE;
        end
    end

    assign sel_scu  = req && (kind == W_SCU);
    assign sel_dist = req && (kind == W_DIST);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign sel_cpuif[g] = req && (kind == W_CPUIF) && (slot == PAGE_W'(g));
        assign sel_timer[g] = req && (kind == W_TIMER) && (slot == PAGE_W'(g));
        assign sel_wdog[g]  = req && (kind == W_WDOG)  && (slot == PAGE_W'(g));
    end

endmodule

// File: rtl/snoop_regs.sv
module snoop_regs
    import snoop_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic              bad_off
);
    localparam logic [DATA_W-1:0] CFG_VAL =
        DATA_W'(((1 << NCPU) - 1) << 4) | DATA_W'(NCPU - 1);

    logic ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (wr_en && off == OFF_CTRL)
            ctrl_q <= wdata[0];
    end

    always_comb begin
        bad_off = 1'b0;
        rd_val  = '0;
        unique case (off)
            OFF_CTRL:  rd_val = {{(DATA_W-1){1'b0}}, ctrl_q};
            OFF_CFG:   rd_val = CFG_VAL;
            OFF_STAT:  rd_val = '0;
            OFF_INVAL: rd_val = '0;
            default:   bad_off = 1'b1;
        endcase
    end

endmodule

// File: rtl/snoop_ctl_block.sv
module snoop_ctl_block
    import snoop_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [12:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              sel_scu,
    output logic [NCPU:0]     sel_cpuif,
    output logic [NCPU:0]     sel_timer,
    output logic [NCPU:0]     sel_wdog,
    output logic              sel_dist
);
    resp_state_e       state_q, state_d;
    win_kind_e         kind;
    logic [DATA_W-1:0] reg_val, rdata_q, rdata_d;
    logic              bad_off, err_q, err_d, scu_hit;

    snoop_win_decode #(.NCPU(NCPU)) u_dec (
        .req       (req),
        .addr      (addr),
        .kind      (kind),
        .sel_scu   (sel_scu),
        .sel_cpuif (sel_cpuif),
        .sel_timer (sel_timer),
        .sel_wdog  (sel_wdog),
        .sel_dist  (sel_dist)
    );

    assign scu_hit = req && (kind == W_SCU);

    snoop_regs #(.NCPU(NCPU)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (scu_hit && we),
        .off     (addr[7:0]),
        .wdata   (wdata),
        .rd_val  (reg_val),
        .bad_off (bad_off)
    );

    assign err_d   = req && ((kind == W_NONE) || (scu_hit && bad_off));
    assign rdata_d = (scu_hit && !we && !bad_off) ? reg_val : '0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req)  state_d = S_RESP;
            S_RESP: if (!req) state_d = S_IDLE;
            default:          state_d = S_IDLE;
        endcase
    end

    // State and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
            err_q   <= err_d;
        end
    end

    // Outputs by state
    always_comb begin
        rdata = '0;
        err   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_RESP: begin
                rdata = rdata_q;
                err   = err_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/snoop_ctl_chk.sv
module snoop_ctl_chk #(
    parameter int NCPU = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          we,
    input logic [12:0]   addr,
    input logic [31:0]   rdata,
    input logic          err,
    input logic          sel_scu,
    input logic [NCPU:0] sel_cpuif,
    input logic [NCPU:0] sel_timer,
    input logic [NCPU:0] sel_wdog,
    input logic          sel_dist
);
    localparam logic [31:0] CFG_EXP = 32'(((1 << NCPU) - 1) << 4) | 32'(NCPU - 1);

    logic [3*NCPU+4:0] sels;
    assign sels = {sel_dist, sel_wdog, sel_timer, sel_cpuif, sel_scu};

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels));

    // R11
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (sels == '0));

    // R10
    miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sels == '0) |=> err);

    // R6
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (rdata == '0 && !err));

    // R2
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && sel_scu && addr[7:0] == 8'h00) |=> (rdata[31:1] == '0 && !err));

    // R3
    cfg_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && sel_scu && addr[7:0] == 8'h04) |=> (rdata == CFG_EXP));

    // R7
    dist_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sel_dist) |=> !err);

endmodule

bind snoop_ctl_block snoop_ctl_chk #(.NCPU(NCPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .rdata     (rdata),
    .err       (err),
    .sel_scu   (sel_scu),
    .sel_cpuif (sel_cpuif),
    .sel_timer (sel_timer),
    .sel_wdog  (sel_wdog),
    .sel_dist  (sel_dist)
);

// File: tb/snoop_ctl_block_test.sv
module snoop_ctl_block_test;
    localparam int NCPU = 4;
    localparam int SW   = 3 * NCPU + 5;

    typedef struct packed {
        logic          we;
        logic [12:0]   addr;
        logic [31:0]   wdata;
        logic [31:0]   exp_rd;
        logic          exp_err;
        logic [SW-1:0] exp_sel;
        logic [3:0]    rq;
    } vec_t;

    // exp_sel bits: 0 scu, 5:1 cpuif, 10:6 timer, 15:11 wdog, 16 dist
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 13'h000, 32'h0,        32'h0,   1'b0, 17'h00001, 4'd1},  // R1 ctrl zero
        '{1'b1, 13'h000, 32'hFFFFFFFF, 32'h0,   1'b0, 17'h00001, 4'd2},  // R2 write
        '{1'b0, 13'h000, 32'h0,        32'h1,   1'b0, 17'h00001, 4'd2},  // R2 bit0 kept
        '{1'b0, 13'h004, 32'h0,        32'hF3,  1'b0, 17'h00001, 4'd3},  // R3 config
        '{1'b0, 13'h008, 32'h0,        32'h0,   1'b0, 17'h00001, 4'd4},  // R4 status
        '{1'b0, 13'h00C, 32'h0,        32'h0,   1'b0, 17'h00001, 4'd4},  // R4 inval read
        '{1'b1, 13'h00C, 32'h0,        32'h0,   1'b0, 17'h00001, 4'd4},  // R4 inval write
        '{1'b0, 13'h000, 32'h0,        32'h1,   1'b0, 17'h00001, 4'd4},  // R4 ctrl kept
        '{1'b0, 13'h010, 32'h0,        32'h0,   1'b1, 17'h00001, 4'd5},  // R5 bad read
        '{1'b1, 13'h001, 32'h0,        32'h0,   1'b1, 17'h00001, 4'd5},  // R5 bad write
        '{1'b0, 13'h0FF, 32'h0,        32'h0,   1'b1, 17'h00001, 4'd5},  // R5 top offset
        '{1'b0, 13'h000, 32'h0,        32'h1,   1'b0, 17'h00001, 4'd5},  // R5 ctrl kept
        '{1'b1, 13'h000, 32'hFFFFFFFE, 32'h0,   1'b0, 17'h00001, 4'd2},  // R2 clear
        '{1'b0, 13'h000, 32'h0,        32'h0,   1'b0, 17'h00001, 4'd2},  // R2 reads 0
        '{1'b0, 13'h100, 32'h0,        32'h0,   1'b0, 17'h00002, 4'd8},  // R8 current
        '{1'b1, 13'h5FC, 32'h5,        32'h0,   1'b0, 17'h00020, 4'd8},  // R8 core 3
        '{1'b0, 13'h600, 32'h0,        32'h0,   1'b0, 17'h00040, 4'd9},  // R9 timer0
        '{1'b0, 13'h91F, 32'h0,        32'h0,   1'b0, 17'h00200, 4'd9},  // R9 timer3
        '{1'b0, 13'h720, 32'h0,        32'h0,   1'b0, 17'h01000, 4'd9},  // R9 wdog1
        '{1'b0, 13'hA3C, 32'h0,        32'h0,   1'b0, 17'h08000, 4'd9},  // R9 wdog4
        '{1'b0, 13'h640, 32'h0,        32'h0,   1'b1, 17'h00000, 4'd10}, // R10 past wdog
        '{1'b0, 13'hB00, 32'h0,        32'h0,   1'b1, 17'h00000, 4'd10}, // R10 gap
        '{1'b0, 13'h1FFC, 32'h0,       32'h0,   1'b0, 17'h10000, 4'd7}   // R7 dist
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [12:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          err;
    logic          sel_scu, sel_dist;
    logic [NCPU:0] sel_cpuif, sel_timer, sel_wdog;
    logic [SW-1:0] sels;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    snoop_ctl_block #(.NCPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .err(err), .sel_scu(sel_scu), .sel_cpuif(sel_cpuif),
        .sel_timer(sel_timer), .sel_wdog(sel_wdog), .sel_dist(sel_dist)
    );

    assign sels = {sel_dist, sel_wdog, sel_timer, sel_cpuif, sel_scu};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request cycle; selects sampled in-cycle, response one edge later
    task automatic access(input logic w, input logic [12:0] a, input logic [31:0] d,
                          output logic [SW-1:0] s, output logic [31:0] rd, output logic e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1 s = sels;
        @(negedge clk);
        rd = rdata; e = err;
        req = 1'b0; we = 1'b0;
    endtask

    initial begin
        logic [SW-1:0] s;
        logic [31:0]   rd;
        logic          e;
        repeat (3) @(negedge clk);
        // R1 outputs at reset
        check("R1 rdata at reset", rdata, 32'h0);
        check("R1 err at reset", {31'h0, err}, 32'h0);
        check("R1 sels at reset", {15'h0, sels}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, s, rd, e);
            check($sformatf("R%0d sel vec%0d", VECS[i].rq, i), {15'h0, s}, {15'h0, VECS[i].exp_sel});
            check($sformatf("R%0d rdata vec%0d", VECS[i].rq, i), rd, VECS[i].exp_rd);
            check($sformatf("R%0d err vec%0d", VECS[i].rq, i), {31'h0, e}, {31'h0, VECS[i].exp_err});
            // R6 response gone one cycle later
            @(negedge clk);
            check("R6 rdata idle", rdata, 32'h0);
            check("R6 err idle", {31'h0, err}, 32'h0);
        end

        // R11 address on the bus without req selects nothing
        @(negedge clk);
        addr = 13'h0600; #1;
        check("R11 no sel without req", {15'h0, sels}, 32'h0);

        // R6 back-to-back: bad access then config read
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 13'h0B00;
        @(negedge clk);
        check("R6 b2b err first", {31'h0, err}, 32'h1);
        addr = 13'h004;
        @(negedge clk);
        check("R6 b2b rdata second", rdata, 32'hF3);
        check("R6 b2b err cleared", {31'h0, err}, 32'h0);
        req = 1'b0;

        // R1 reset clears control
        access(1'b1, 13'h000, 32'h1, s, rd, e);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 13'h000, 32'h0, s, rd, e);
        check("R1 ctrl cleared by reset", rd, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule